// File: doc/BRIEF.md
# Processor Status and Mode Register

This block holds the eight condition and control flags of a 16-bit-capable processor core, together with a hidden mode bit. The mode bit selects between a compatibility mode, in which the core behaves as an 8-bit machine, and a full-width native mode. The execution unit drives one operation code per cycle, with an 8-bit immediate and ALU flag results where the operation needs them. The block applies the update at the next rising clock edge.

The supported updates are:

- setting or clearing any group of flags through a one-byte mask;
- single-flag set and clear commands;
- restoring the whole byte as it was pulled from the stack;
- loading the ALU's negative, overflow, zero and carry results under per-flag write enables;
- exchanging the carry with the mode bit.

The accumulator-width and index-width flags go straight to the datapath as width selects. When the index width becomes 8-bit, the block raises a one-cycle pulse so that the index registers drop their high bytes.

The mode bit is held by a two-state machine with the states `MODE_EMU` (compatibility) and `MODE_NAT` (native). It has two transitions:

- `MODE_EMU` goes to `MODE_NAT` on an exchange while carry is 0.
- `MODE_NAT` goes to `MODE_EMU` on an exchange while carry is 1.

An exchange that finds carry equal to the current mode keeps the state. While the state is `MODE_EMU`, both width flags are held at 1.

Top module: `psr_unit`

## Requirements
- R1: Reset (rst_n low) sets the mode bit to 1 and the status byte to 0x34. Bit positions from bit 0 upward are: carry 0, zero 1, IRQ disable 2, decimal 3, index width 4, accumulator width 5, overflow 6, negative 7. The reset byte therefore has IRQ disable and both width flags set and all other flags clear, and idx_trunc_o is 0.
- R2: op 1 (set by mask) sets every status bit whose imm_i bit is 1 and leaves the other bits unchanged.
- R3: op 2 (clear by mask) clears every status bit whose imm_i bit is 1 and leaves the other bits unchanged, except that the width bits stay 1 in compatibility mode.
- R4: Single-flag commands change only their own flag: op 3 clears carry, 4 sets carry, 5 clears decimal, 6 sets decimal, 7 clears IRQ disable, 8 sets IRQ disable, 9 clears overflow.
- R5: op 10 (pull restore) overwrites all eight bits with imm_i; in compatibility mode bits 4 and 5 still read 1.
- R6: op 11 loads alu_flags_i = {negative, overflow, zero, carry} into bits 7, 6, 1, 0, each only where the matching alu_we_i bit is 1.
- R7: op 12 (exchange) makes the new mode bit the old carry and the new carry the old mode bit.
- R8: Whenever the mode bit is 1, including the cycle an exchange enters compatibility mode, status bits 5 and 4 read 1.
- R9: acc8_o equals status bit 5 and idx8_o equals status bit 4; a 1 selects 8-bit operation and a 0 selects 16-bit.
- R10: idx_trunc_o is 1 for exactly the one cycle in which idx8_o has just changed from 0 to 1, and is 0 otherwise.
- R11: op 0 and op codes 13 to 15 leave the status byte and mode bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Update operation code (see R2 to R7, R11) |
| imm_i | input | 8 | Mask for ops 1 and 2, pulled byte for op 10 |
| alu_flags_i | input | 4 | ALU results {negative, overflow, zero, carry} |
| alu_we_i | input | 4 | Per-flag write enables for op 11, same order |
| status_o | output | 8 | Current status byte |
| emu_o | output | 1 | Mode bit, 1 = compatibility mode |
| acc8_o | output | 1 | Accumulator width select, 1 = 8-bit |
| idx8_o | output | 1 | Index width select, 1 = 8-bit |
| idx_trunc_o | output | 1 | One-cycle pulse when the index width becomes 8-bit |

## Verification
The assertions check on every cycle the properties that hold whatever op arrives:

- the width flags are pinned while in compatibility mode;
- the carry and mode bit swap on an exchange;
- every masked bit lands as requested after a mask operation;
- the truncation pulse coincides exactly with the index width rising.

Only the bench's ordered scenarios can show the rest:

- the exact byte produced by chains of single-flag commands, partial ALU write enables and pull restores;
- that op codes without an assigned meaning disturb nothing;
- that a mid-run reset returns the byte to 0x34.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int FLAG_W = 8;
    localparam int ALU_W  = 4;

    localparam int B_C = 0;
    localparam int B_Z = 1;
    localparam int B_I = 2;
    localparam int B_D = 3;
    localparam int B_X = 4;
    localparam int B_M = 5;
    localparam int B_V = 6;
    localparam int B_N = 7;

    localparam logic [FLAG_W-1:0] WIDTH_MASK = (FLAG_W'(1) << B_X) | (FLAG_W'(1) << B_M);
    localparam logic [FLAG_W-1:0] RESET_BYTE = WIDTH_MASK | (FLAG_W'(1) << B_I);

    typedef enum logic [3:0] {
        OP_NONE     = 4'd0,
        OP_SET_MASK = 4'd1,
        OP_CLR_MASK = 4'd2,
        OP_CLR_C    = 4'd3,
        OP_SET_C    = 4'd4,
        OP_CLR_D    = 4'd5,
        OP_SET_D    = 4'd6,
        OP_CLR_I    = 4'd7,
        OP_SET_I    = 4'd8,
        OP_CLR_V    = 4'd9,
        OP_PULL     = 4'd10,
        OP_ALU      = 4'd11,
        OP_SWAP_CE  = 4'd12
    } psr_op_e;

    typedef enum logic {
        MODE_NAT = 1'b0,
        MODE_EMU = 1'b1
    } psr_mode_e;

endpackage

// File: rtl/psr_mode_fsm.sv
module psr_mode_fsm
    import psr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_i,
    input  logic carry_i,
    output logic emu_o,
    output logic emu_next_o
);

    psr_mode_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_EMU;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_EMU: if (swap_i && !carry_i) state_d = MODE_NAT;
            MODE_NAT: if (swap_i &&  carry_i) state_d = MODE_EMU;
            default:  state_d = MODE_EMU;
        endcase
    end

    always_comb begin
        emu_o      = (state_q == MODE_EMU);
        emu_next_o = (state_d == MODE_EMU);
    end

    // R7: the mode after an exchange equals the carry before it
    assert_swap_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swap_i |=> (emu_o == $past(carry_i)));

endmodule

// File: rtl/psr_flag_next.sv
module psr_flag_next
    import psr_pkg::*;
(
    input  logic [FLAG_W-1:0] cur_i,
    input  logic              emu_i,
    input  logic [3:0]        op_i,
    input  logic [FLAG_W-1:0] imm_i,
    input  logic [ALU_W-1:0]  alu_flags_i,
    input  logic [ALU_W-1:0]  alu_we_i,
    output logic [FLAG_W-1:0] raw_next_o,
    output logic              swap_o
);

    psr_op_e op;
    assign op = psr_op_e'(op_i);

    always_comb begin
        raw_next_o = cur_i;
        swap_o     = 1'b0;
        case (op)
            OP_SET_MASK: raw_next_o = cur_i | imm_i;
            OP_CLR_MASK: raw_next_o = cur_i & ~imm_i;
            OP_CLR_C:    raw_next_o[B_C] = 1'b0;
            OP_SET_C:    raw_next_o[B_C] = 1'b1;
            OP_CLR_D:    raw_next_o[B_D] = 1'b0;
            OP_SET_D:    raw_next_o[B_D] = 1'b1;
            OP_CLR_I:    raw_next_o[B_I] = 1'b0;
            OP_SET_I:    raw_next_o[B_I] = 1'b1;
            OP_CLR_V:    raw_next_o[B_V] = 1'b0;
            OP_PULL:     raw_next_o = imm_i;
            OP_ALU: begin
                if (alu_we_i[3]) raw_next_o[B_N] = alu_flags_i[3];
                if (alu_we_i[2]) raw_next_o[B_V] = alu_flags_i[2];
                if (alu_we_i[1]) raw_next_o[B_Z] = alu_flags_i[1];
                if (alu_we_i[0]) raw_next_o[B_C] = alu_flags_i[0];
            end
            OP_SWAP_CE: begin
                raw_next_o[B_C] = emu_i;
                swap_o          = 1'b1;
            end
            default: raw_next_o = cur_i;
        endcase
    end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
    import psr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  op_i,
    input  logic [7:0]  imm_i,
    input  logic [3:0]  alu_flags_i,
    input  logic [3:0]  alu_we_i,
    output logic [7:0]  status_o,
    output logic        emu_o,
    output logic        acc8_o,
    output logic        idx8_o,
    output logic        idx_trunc_o
);

    logic [FLAG_W-1:0] p_q, raw_next, p_next;
    logic              emu_q, emu_next, swap;
    logic              trunc_q;

    psr_flag_next u_next (
        .cur_i       (p_q),
        .emu_i       (emu_q),
        .op_i        (op_i),
        .imm_i       (imm_i),
        .alu_flags_i (alu_flags_i),
        .alu_we_i    (alu_we_i),
        .raw_next_o  (raw_next),
        .swap_o      (swap)
    );

    psr_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap_i     (swap),
        .carry_i    (p_q[B_C]),
        .emu_o      (emu_q),
        .emu_next_o (emu_next)
    );

    assign p_next = emu_next ? (raw_next | WIDTH_MASK) : raw_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q     <= RESET_BYTE;
            trunc_q <= 1'b0;
        end else begin
            p_q     <= p_next;
            trunc_q <= ~p_q[B_X] & p_next[B_X];
        end
    end

    always_comb begin
        status_o    = p_q;
        emu_o       = emu_q;
        acc8_o      = p_q[B_M];
        idx8_o      = p_q[B_X];
        idx_trunc_o = trunc_q;
    end

    // R8: compatibility mode pins both width flags
    assert_emu_widths_R8: assert property (@(posedge clk) disable iff (!rst_n)
        emu_o |-> (status_o[5:4] == 2'b11));

    // R7: carry after an exchange equals the previous mode bit
    assert_swap_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd12) |=> (status_o[0] == $past(emu_o)));

    // R2: every masked bit is set afterwards
    assert_mask_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1) |=> ((status_o & $past(imm_i)) == $past(imm_i)));

    // R3: every masked bit is clear afterwards (widths excepted in compatibility mode)
    assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd2) |=> ((status_o & $past(imm_i) & (emu_o ? 8'hCF : 8'hFF)) == 8'h00));

    // R10: pulse only alongside an 8-bit index width
    assert_trunc_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        idx_trunc_o |-> idx8_o);

    // R10: every rise of the index width raises the pulse
    assert_trunc_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idx8_o) |-> idx_trunc_o);

    // R11: unassigned codes keep the byte
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i > 4'd12) |=> $stable(status_o));

endmodule

// File: tb/psr_unit_bench.sv
module psr_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] op_i;
    logic [7:0] imm_i;
    logic [3:0] alu_flags_i;
    logic [3:0] alu_we_i;
    logic [7:0] status_o;
    logic       emu_o, acc8_o, idx8_o, idx_trunc_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_unit u_psr_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_i(imm_i),
        .alu_flags_i(alu_flags_i), .alu_we_i(alu_we_i),
        .status_o(status_o), .emu_o(emu_o), .acc8_o(acc8_o),
        .idx8_o(idx8_o), .idx_trunc_o(idx_trunc_o)
    );

    // {op, imm, alu_flags, alu_we, exp_status, exp_emu, exp_trunc}
    localparam logic [29:0] VEC [NVEC] = '{
        {4'd1,  8'hC3, 4'h0, 4'h0, 8'hF7, 1'b1, 1'b0},
        {4'd2,  8'hFF, 4'h0, 4'h0, 8'h30, 1'b1, 1'b0},
        {4'd4,  8'h00, 4'h0, 4'h0, 8'h31, 1'b1, 1'b0},
        {4'd12, 8'h00, 4'h0, 4'h0, 8'h31, 1'b1, 1'b0},
        {4'd3,  8'h00, 4'h0, 4'h0, 8'h30, 1'b1, 1'b0},
        {4'd12, 8'h00, 4'h0, 4'h0, 8'h31, 1'b0, 1'b0},
        {4'd2,  8'h10, 4'h0, 4'h0, 8'h21, 1'b0, 1'b0},
        {4'd2,  8'h20, 4'h0, 4'h0, 8'h01, 1'b0, 1'b0},
        {4'd1,  8'h10, 4'h0, 4'h0, 8'h11, 1'b0, 1'b1},
        {4'd0,  8'hFF, 4'hF, 4'hF, 8'h11, 1'b0, 1'b0},
        {4'd6,  8'h00, 4'h0, 4'h0, 8'h19, 1'b0, 1'b0},
        {4'd8,  8'h00, 4'h0, 4'h0, 8'h1D, 1'b0, 1'b0},
        {4'd7,  8'h00, 4'h0, 4'h0, 8'h19, 1'b0, 1'b0},
        {4'd5,  8'h00, 4'h0, 4'h0, 8'h11, 1'b0, 1'b0},
        {4'd11, 8'h00, 4'hE, 4'hF, 8'hD2, 1'b0, 1'b0},
        {4'd11, 8'h00, 4'h1, 4'h5, 8'h93, 1'b0, 1'b0},
        {4'd1,  8'h40, 4'h0, 4'h0, 8'hD3, 1'b0, 1'b0},
        {4'd9,  8'h00, 4'h0, 4'h0, 8'h93, 1'b0, 1'b0},
        {4'd10, 8'h2A, 4'h0, 4'h0, 8'h2A, 1'b0, 1'b0},
        {4'd10, 8'h00, 4'h0, 4'h0, 8'h00, 1'b0, 1'b0},
        {4'd1,  8'h01, 4'h0, 4'h0, 8'h01, 1'b0, 1'b0},
        {4'd12, 8'h00, 4'h0, 4'h0, 8'h30, 1'b1, 1'b1},
        {4'd10, 8'h00, 4'h0, 4'h0, 8'h30, 1'b1, 1'b0},
        {4'd15, 8'hFF, 4'hF, 4'hF, 8'h30, 1'b1, 1'b0},
        {4'd2,  8'h30, 4'h0, 4'h0, 8'h30, 1'b1, 1'b0},
        {4'd12, 8'h00, 4'h0, 4'h0, 8'h31, 1'b0, 1'b0}
    };

    string vtag [NVEC] = '{
        "R2", "R3 R8", "R4", "R7", "R4", "R7",
        "R3 R9", "R3 R9", "R2 R10", "R11",
        "R4", "R4", "R4", "R4", "R6", "R6", "R2", "R4",
        "R5", "R5", "R2", "R7 R8 R10", "R5 R8", "R11", "R3 R8", "R7"
    };

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: {status,emu,trunc} actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [9:0] observe();
        return {status_o, emu_o, idx_trunc_o};
    endfunction

    initial begin
        rst_n = 1'b0; op_i = 4'd0; imm_i = 8'h00; alu_flags_i = 4'h0; alu_we_i = 4'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", observe(), {8'h34, 1'b1, 1'b0});
        check("R9 reset widths", {8'h00, acc8_o, idx8_o}, {8'h00, 1'b1, 1'b1});
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            op_i        = VEC[i][29:26];
            imm_i       = VEC[i][25:18];
            alu_flags_i = VEC[i][17:14];
            alu_we_i    = VEC[i][13:10];
            @(posedge clk);
            #1;
            check(vtag[i], observe(), VEC[i][9:0]);
            check("R9 width outputs", {8'h00, acc8_o, idx8_o}, {8'h00, status_o[5], status_o[4]});
            @(negedge clk);
        end
        // R10: pulse lasts a single cycle
        op_i = 4'd2; imm_i = 8'h10;
        @(posedge clk); #1;
        @(negedge clk); op_i = 4'd1; imm_i = 8'h10;
        @(posedge clk); #1;
        check("R10 pulse on", observe(), {8'h31, 1'b0, 1'b1});
        @(negedge clk); op_i = 4'd0;
        @(posedge clk); #1;
        check("R10 pulse off", observe(), {8'h31, 1'b0, 1'b0});
        // R1: reset from native mode with flags set
        @(negedge clk); op_i = 4'd1; imm_i = 8'hCB;
        @(posedge clk); #1;
        @(negedge clk); rst_n = 1'b0; op_i = 4'd0;
        @(posedge clk); #1;
        check("R1 mid-run reset", observe(), {8'h34, 1'b1, 1'b0});
        @(negedge clk); rst_n = 1'b1;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule